// File: doc/BRIEF.md
# Hardware Counting Semaphore Bank

A bank of counting semaphores shared by several requesters. Each requester owns a request port with a valid/ready handshake that carries an operation (acquire, written P, or release, written V) and a semaphore index. The block keeps one non-negative count per semaphore and performs exactly one operation per cycle, so every read-modify-write of a count is atomic with respect to all other requesters.

An acquire on a positive count decrements it and completes. An acquire on a zero count is parked in hardware: the requester keeps its valid high and sees no ready until a later release on the same semaphore wakes it. A release that finds parked requesters hands the unit straight to one of them (the count is unchanged, as if incremented and then decremented at once), choosing waiters in round-robin order. A separate init port loads a count, which sets how many holders the semaphore admits; a value of 1 makes a mutex. Loading a semaphore that has parked waiters is refused.

Top module: `sem_unit`

## Requirements
- R1: After reset every count is 0, `req_ready_o` is all zero, and `init_ack_o`, `init_err_o` and `ovf_o` are 0.
- R2: An accepted P (op bit 0) on a semaphore whose count is above zero decrements it by one and raises that requester's `req_ready_o` for exactly one cycle, in the cycle after the one in which it was selected.
- R3: An accepted P on a semaphore whose count is 0 leaves the count at 0 and parks the requester: it gets no ready while it stays parked.
- R4: An accepted V (op bit 1) on a semaphore with no parked waiter raises the releaser's ready for one cycle and increments the count by one.
- R5: An accepted V on a semaphore with parked waiters raises the releaser's ready and exactly one waiter's ready in the same cycle, and leaves the count unchanged.
- R6: Waiters on one semaphore are woken in round-robin order, starting from the requester index after the one last woken on that semaphore (requester 0 first after reset).
- R7: At most one request is accepted per cycle; among eligible requests the one chosen is the first at or after the requester index following the last accepted one, wrapping around (requester 0 first after reset). A requester's ready is only raised when its valid was high the cycle before.
- R8: A pulse on `init_valid_i` loads `init_val_i` into semaphore `init_idx_i` and gives `init_ack_o` for one cycle in the following cycle, with `init_err_o` low.
- R9: If any requester is parked on the semaphore named by the init port, the load is refused: the count is unchanged and `init_ack_o` and `init_err_o` are both high in the following cycle.
- R10: A V with no waiters on a count already equal to 2^CNT_W-1 leaves the count at its maximum, still completes, and sets `ovf_o`, which stays high until reset.
- R11: In a cycle with `init_valid_i` high no request is accepted; requests pending in that cycle are served afterwards against the newly loaded count, and no ready is raised in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Request valid per requester, held until ready |
| req_op_i | input | N_REQ | Operation per requester: 0 = P (acquire), 1 = V (release) |
| req_idx_i | input | N_REQ*IDX_W | Semaphore index per requester, requester i at bits [i*IDX_W +: IDX_W] |
| req_ready_o | output | N_REQ | One-cycle completion pulse per requester |
| init_valid_i | input | 1 | Load request for one semaphore count |
| init_idx_i | input | IDX_W | Semaphore to load |
| init_val_i | input | CNT_W | Count value to load |
| init_ack_o | output | 1 | Load handled (one cycle after init_valid_i) |
| init_err_o | output | 1 | Load refused because of parked waiters |
| ovf_o | output | 1 | Sticky count saturation flag |

## Verification
The hardest situation to reach from the ports is a semaphore with two parked waiters whose round-robin wake order differs from plain index priority. The bench gets there by first waking requester 0, then parking requesters 2 and 3, waking 2, and parking requester 0 again, so that the next release must pick requester 3 ahead of the lower index 0. The count left behind after a handover is invisible at the ports, so it is probed by a further acquire that must park. Arbitration rotation and init precedence are brought out by raising several valids, or a valid and an init, on the same clock edge.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_DEC  = 2'd1,
    UPD_INC  = 2'd2,
    UPD_LOAD = 2'd3
  } upd_e;

  localparam logic OP_ACQ = 1'b0;
  localparam logic OP_REL = 1'b1;
endpackage

// File: rtl/sem_rr_pick.sv
// Rotating-priority picker: first request strictly after last_i, wrapping.
module sem_rr_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] last_i,
  output logic [N-1:0] gnt_o,
  output logic [W-1:0] gnt_idx_o,
  output logic         any_o
);
  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    any_o     = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last_i) + k) % N;
      if (!any_o && req_i[j]) begin
        any_o     = 1'b1;
        gnt_o[j]  = 1'b1;
        gnt_idx_o = W'(j);
      end
    end
  end
endmodule

// File: rtl/sem_count_bank.sv
module sem_count_bank
  import sem_pkg::*;
#(
  parameter int N_SEM = 8,
  parameter int CNT_W = 4,
  localparam int IDX_W = (N_SEM > 1) ? $clog2(N_SEM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_zero_o,
  output logic             rd_max_o,
  input  upd_e             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [CNT_W-1:0] load_val_i
);
  logic [CNT_W-1:0] cnt_q [N_SEM];

  for (genvar g = 0; g < N_SEM; g++) begin : g_sem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[g] <= '0;
      end else if (upd_i != UPD_NONE && upd_idx_i == IDX_W'(g)) begin
        case (upd_i)
          UPD_DEC:  cnt_q[g] <= cnt_q[g] - CNT_W'(1);
          UPD_INC:  cnt_q[g] <= cnt_q[g] + CNT_W'(1);
          UPD_LOAD: cnt_q[g] <= load_val_i;
          default:  cnt_q[g] <= cnt_q[g];
        endcase
      end
    end
  end

  assign rd_zero_o = (cnt_q[rd_idx_i] == '0);
  assign rd_max_o  = (cnt_q[rd_idx_i] == '1);
endmodule

// File: rtl/sem_unit.sv
module sem_unit
  import sem_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int N_SEM = 8,
  parameter int CNT_W = 4,
  localparam int REQ_W = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int IDX_W = (N_SEM > 1) ? $clog2(N_SEM) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_REQ-1:0]       req_valid_i,
  input  logic [N_REQ-1:0]       req_op_i,
  input  logic [N_REQ*IDX_W-1:0] req_idx_i,
  output logic [N_REQ-1:0]       req_ready_o,
  input  logic                   init_valid_i,
  input  logic [IDX_W-1:0]       init_idx_i,
  input  logic [CNT_W-1:0]       init_val_i,
  output logic                   init_ack_o,
  output logic                   init_err_o,
  output logic                   ovf_o
);
  logic [IDX_W-1:0] idx_of [N_REQ];
  logic [N_REQ-1:0] wait_q, ready_q, elig;
  logic [REQ_W-1:0] rr_q;
  logic [REQ_W-1:0] wake_ptr_q [N_SEM];
  logic             ovf_q, ack_q, err_q;

  logic [N_REQ-1:0] win_oh, wake_req, wake_oh;
  logic [REQ_W-1:0] win, wake_sel;
  logic             win_any, wake_any;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_op, init_busy;
  logic             cnt_zero, cnt_max;

  upd_e             upd;
  logic [IDX_W-1:0] upd_idx;
  logic [N_REQ-1:0] ready_d, wait_set, wait_clr;
  logic             ovf_set, wake_fire;

  always_comb begin
    for (int i = 0; i < N_REQ; i++) idx_of[i] = req_idx_i[i*IDX_W +: IDX_W];
  end

  // parked and just-completed requesters do not compete; init blocks all
  assign elig = req_valid_i & ~wait_q & ~ready_q & {N_REQ{~init_valid_i}};

  sem_rr_pick #(.N(N_REQ)) u_req_arb (
    .req_i     (elig),
    .last_i    (rr_q),
    .gnt_o     (win_oh),
    .gnt_idx_o (win),
    .any_o     (win_any)
  );

  assign sel_idx = idx_of[win];
  assign sel_op  = req_op_i[win];

  always_comb begin
    wake_req  = '0;
    init_busy = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      wake_req[i] = wait_q[i] && (idx_of[i] == sel_idx);
      if (wait_q[i] && idx_of[i] == init_idx_i) init_busy = 1'b1;
    end
  end

  sem_rr_pick #(.N(N_REQ)) u_wake_arb (
    .req_i     (wake_req),
    .last_i    (wake_ptr_q[sel_idx]),
    .gnt_o     (wake_oh),
    .gnt_idx_o (wake_sel),
    .any_o     (wake_any)
  );

  sem_count_bank #(.N_SEM(N_SEM), .CNT_W(CNT_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (sel_idx),
    .rd_zero_o  (cnt_zero),
    .rd_max_o   (cnt_max),
    .upd_i      (upd),
    .upd_idx_i  (upd_idx),
    .load_val_i (init_val_i)
  );

  always_comb begin
    upd       = UPD_NONE;
    upd_idx   = sel_idx;
    ready_d   = '0;
    wait_set  = '0;
    wait_clr  = '0;
    ovf_set   = 1'b0;
    wake_fire = 1'b0;
    if (init_valid_i) begin
      if (!init_busy) begin
        upd     = UPD_LOAD;
        upd_idx = init_idx_i;
      end
    end else if (win_any) begin
      if (sel_op == OP_ACQ) begin
        if (!cnt_zero) begin
          upd     = UPD_DEC;
          ready_d = win_oh;
        end else begin
          wait_set = win_oh;
        end
      end else begin
        ready_d = win_oh;
        if (wake_any) begin
          // hand the unit over: count stays, waiter completes
          ready_d   = win_oh | wake_oh;
          wait_clr  = wake_oh;
          wake_fire = 1'b1;
        end else if (cnt_max) begin
          ovf_set = 1'b1;
        end else begin
          upd = UPD_INC;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q  <= '0;
      ready_q <= '0;
      rr_q    <= REQ_W'(N_REQ - 1);
      ovf_q   <= 1'b0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      wait_q  <= (wait_q | wait_set) & ~wait_clr;
      ready_q <= ready_d;
      if (win_any && !init_valid_i) rr_q <= win;
      ovf_q   <= ovf_q | ovf_set;
      ack_q   <= init_valid_i;
      err_q   <= init_valid_i && init_busy;
    end
  end

  for (genvar s = 0; s < N_SEM; s++) begin : g_wptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wake_ptr_q[s] <= REQ_W'(N_REQ - 1);
      end else if (wake_fire && sel_idx == IDX_W'(s)) begin
        wake_ptr_q[s] <= wake_sel;
      end
    end
  end

  assign req_ready_o = ready_q;
  assign init_ack_o  = ack_q;
  assign init_err_o  = err_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
  parameter int N_REQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_valid_i,
  input logic [N_REQ-1:0] req_ready_o,
  input logic             init_valid_i,
  input logic             init_ack_o,
  input logic             init_err_o,
  input logic             ovf_o
);
  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o[i] |=> !req_ready_o[i]); // R2
    AST_READY_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o[i] |-> $past(req_valid_i[i])); // R7
  end

  AST_AT_MOST_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(req_ready_o) <= 2); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R10
  AST_INIT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_valid_i |=> init_ack_o); // R8
  AST_ERR_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_err_o |-> init_ack_o); // R9
  AST_INIT_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_valid_i |=> (req_ready_o == '0)); // R11
endmodule

bind sem_unit sem_unit_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .init_valid_i (init_valid_i),
  .init_ack_o   (init_ack_o),
  .init_err_o   (init_err_o),
  .ovf_o        (ovf_o)
);

// File: tb/sem_unit_tb_top.sv
module sem_unit_tb_top;
  localparam int N_REQ = 4;
  localparam int N_SEM = 8;
  localparam int CNT_W = 4;
  localparam int IDX_W = 3;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [N_REQ-1:0]       valid = '0;
  logic [N_REQ-1:0]       op = '0;
  logic [N_REQ*IDX_W-1:0] idx = '0;
  logic [N_REQ-1:0]       ready;
  logic                   init_v = 1'b0;
  logic [IDX_W-1:0]       init_idx = '0;
  logic [CNT_W-1:0]       init_val = '0;
  logic                   ack, err, ovf;

  int checks = 0;
  int errors = 0;
  logic [N_REQ-1:0] exp_q [$];
  string            tag_q [$];

  always #5 clk = ~clk;

  sem_unit #(.N_REQ(N_REQ), .N_SEM(N_SEM), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_op_i(op),
    .req_idx_i(idx), .req_ready_o(ready), .init_valid_i(init_v),
    .init_idx_i(init_idx), .init_val_i(init_val), .init_ack_o(ack),
    .init_err_o(err), .ovf_o(ovf));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_done(input logic [N_REQ-1:0] mask, input string tag);
    exp_q.push_back(mask);
    tag_q.push_back(tag);
  endtask

  // caller is at a negedge
  task automatic start(input int r, input logic o, input int s);
    op[r] = o;
    idx[r*IDX_W +: IDX_W] = IDX_W'(s);
    valid[r] = 1'b1;
  endtask

  task automatic do_init(input int s, input int v, input bit exp_err, input string tag);
    init_idx = IDX_W'(s);
    init_val = CNT_W'(v);
    init_v = 1'b1;
    @(negedge clk);
    init_v = 1'b0;
    check(ack == 1'b1, tag, int'(ack), 1);
    check(err == exp_err, tag, int'(err), int'(exp_err));
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, "drain", exp_q.size(), 0);
    @(negedge clk);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      #2;
      check(ready == '0, tag, int'(ready), 0);
    end
    @(negedge clk);
  endtask

  // monitor: pops expected completions and retires handshakes
  always @(posedge clk) begin
    #1;
    if (rst_n && ready != '0) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected ready", int'(ready), 0);
      end else begin
        logic [N_REQ-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ready == e, t, int'(ready), int'(e));
      end
      valid = valid & ~ready;
    end
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ready == '0, "R1 ready", int'(ready), 0);
    check({ack, err, ovf} == 3'b000, "R1 flags", int'({ack, err, ovf}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == '0 && ovf == 1'b0, "R1 after release", int'(ready), 0);

    // R3: P on empty semaphore 0 parks
    start(0, 1'b0, 0);
    expect_quiet(4, "R3 park");
    // R9: init refused while waiter parked
    do_init(0, 5, 1'b1, "R9 refused");
    expect_quiet(2, "R9 count kept 0");
    // R5: V hands over to the waiter
    expect_done(4'b0011, "R5 handover");
    start(1, 1'b1, 0);
    drain();
    start(2, 1'b0, 0);
    expect_quiet(4, "R5 count unchanged");
    start(3, 1'b0, 0);
    expect_quiet(2, "R3 second waiter");
    // R6: round-robin wake order (last woken 0)
    expect_done(4'b0110, "R6 wake 2");
    start(1, 1'b1, 0);
    drain();
    start(0, 1'b0, 0);
    expect_quiet(2, "R3 park again");
    expect_done(4'b1010, "R6 wake 3 before 0");
    start(1, 1'b1, 0);
    drain();
    expect_done(4'b0011, "R6 wake 0");
    start(1, 1'b1, 0);
    drain();

    // R8 / R2: init then decrement
    do_init(1, 2, 1'b0, "R8 load");
    expect_done(4'b0001, "R2 first P");
    start(0, 1'b0, 1);
    drain();
    expect_done(4'b0010, "R2 second P");
    start(1, 1'b0, 1);
    drain();
    start(2, 1'b0, 1);
    expect_quiet(3, "R2 exhausted");
    expect_done(4'b1100, "R5 wake on sem1");
    start(3, 1'b1, 1);
    drain();

    // R7: simultaneous requests, rotating priority (last winner 3)
    do_init(2, 3, 1'b0, "R8 load sem2");
    expect_done(4'b0001, "R7 order 0");
    expect_done(4'b0010, "R7 order 1");
    expect_done(4'b0100, "R7 order 2");
    start(0, 1'b0, 2); start(1, 1'b0, 2); start(2, 1'b0, 2);
    drain();
    expect_done(4'b1000, "R7 rotate 3");
    expect_done(4'b0001, "R7 rotate 0");
    expect_done(4'b0010, "R7 rotate 1");
    start(0, 1'b1, 2); start(1, 1'b1, 2); start(3, 1'b1, 2);
    drain();

    // R10: saturation
    do_init(3, 15, 1'b0, "R8 load max");
    check(ovf == 1'b0, "R10 before", int'(ovf), 0);
    expect_done(4'b0001, "R10 V at max");
    start(0, 1'b1, 3);
    drain();
    check(ovf == 1'b1, "R10 flag", int'(ovf), 1);
    expect_done(4'b0010, "R10 count kept");
    start(1, 1'b0, 3);
    drain();
    check(ovf == 1'b1, "R10 sticky", int'(ovf), 1);

    // R11: init in the same cycle as a request goes first
    expect_done(4'b0001, "R11 P after load");
    start(0, 1'b0, 4);
    do_init(4, 1, 1'b0, "R11 init first");
    drain();

    // R4: V without waiters increments
    expect_done(4'b0010, "R4 V");
    start(1, 1'b1, 5);
    drain();
    expect_done(4'b0100, "R4 count is 1");
    start(2, 1'b0, 5);
    drain();
    start(3, 1'b0, 5);
    expect_quiet(3, "R4 count back to 0");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule